// File: doc/BRIEF.md
# Multibank DRAM Command Timing Controller

This block checks decoded DRAM commands against per-bank row timing before they reach a memory device. It keeps the state of four banks: whether a row is open, which row it is, and down-counters for the activate-to-column, precharge-to-activate and activate-to-activate spacings. Each command presented with `cmdValid` is judged in the cycle it arrives. One cycle later the block raises either an accept flag or a violation flag. Only accepted commands change bank state.

The timing limits are set in nanoseconds and converted to clock cycles by ceiling division by the clock period parameter. At the default 5 ns clock, activate-to-column and precharge-to-activate are 3 cycles each, and activate-to-activate is 12 cycles. The mode inputs give the CAS latency, the posted additive latency and the burst length. The block reports the resulting read and write latencies. When a column command carries the auto-precharge flag, the block closes the row by itself once the burst is over.

The block also keeps a 13-bit refresh row counter. It raises a refresh request at the average interval needed to cover all 8,192 rows in 64 ms.

Top module: `bank_timing_ctrl`

## Requirements
- R1: An activate (`cmdOp`=1) is accepted only when the addressed bank has no open row and both its precharge-to-activate and activate-to-activate windows have expired. Acceptance opens the bank with the row on `cmdRow`.
- R2: A read (`cmdOp`=2) or write (`cmdOp`=3) is accepted only to an open bank with no auto precharge pending, at least 3 cycles after that bank's activate. On acceptance, `colRow` shows that bank's open row and `colAddr` shows `cmdCol` from the next cycle on.
- R3: Two activates to the same bank must be at least 12 cycles apart. Banks are independent: a command to one bank never changes another bank's timing.
- R4: A precharge (`cmdOp`=4) to an open bank closes it, and an activate to that bank is refused until 3 cycles after the precharge. A precharge to a closed bank is accepted and has no effect on that bank. A precharge is refused while auto precharge is pending on the bank.
- R5: `readLatency` equals `modeAl`+`modeCl`, and `writeLatency` equals `readLatency`−1. A read or write is refused when `modeCl` is not 3 or 4, or when `modeAl` exceeds 4.
- R6: A read with `cmdAutoPre` at edge t pulses the bank's `autoPreFire` bit during the cycle before edge t+D, where D = AL + BL/2. For a write, D = WL + BL/2. The bank closes at edge t+D, and the precharge-to-activate window starts there. `modeBurst8`=1 selects BL 8, otherwise BL 4.
- R7: A refresh (`cmdOp`=5) is accepted only when every bank is closed, its precharge window has expired and no auto precharge is pending. Each accepted refresh advances `refreshRow` by one, modulo 8192.
- R8: `refreshDue` rises 1562 cycles after reset (the floor of 64 ms / 8192 at 5 ns) and again every 1562 cycles after that. An accepted refresh clears it.
- R9: Every valid non-NOP command yields exactly one of `cmdAccept` or `cmdViolation` one cycle later. A NOP (`cmdOp`=0) or an idle cycle yields neither. Codes 6 and 7 are violations. After reset all banks are closed and every output flag is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 3 | 0 NOP, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh |
| cmdBank | input | 2 | Target bank |
| cmdRow | input | 13 | Row for activate |
| cmdCol | input | 10 | Start column for read/write |
| cmdAutoPre | input | 1 | Auto precharge with read/write |
| modeCl | input | 3 | CAS latency |
| modeAl | input | 3 | Additive latency |
| modeBurst8 | input | 1 | 1 selects burst length 8, 0 selects 4 |
| cmdAccept | output | 1 | Previous command accepted |
| cmdViolation | output | 1 | Previous command refused |
| readLatency | output | 4 | AL + CL |
| writeLatency | output | 4 | Read latency − 1 |
| bankOpen | output | 4 | One bit per bank, row open |
| autoPreFire | output | 4 | Per-bank self-timed precharge strobe |
| colRow | output | 13 | Row of last accepted read/write |
| colAddr | output | 10 | Column of last accepted read/write |
| refreshDue | output | 1 | Refresh interval has elapsed |
| refreshRow | output | 13 | Next row to be refreshed |

## Verification
The assertions assume that each command is held for exactly one cycle. They also assume the mode inputs change only while no command is presented and no auto precharge is pending, because a pending precharge uses the delay latched at issue. The bench changes mode only between commands, and only after earlier auto precharges have completed. The bench drives every command at a falling edge, so the bank field and opcode are always stable across the sampling edge.

// File: rtl/bank_timing_pkg.sv
package bank_timing_pkg;

  localparam int NUM_BANKS = 4;
  localparam int BANK_W    = 2;
  localparam int ROW_W     = 13;
  localparam int COL_W     = 10;
  localparam int AP_W      = 5;   // holds WL + BL/2 up to 7 + 4

  localparam logic [2:0] OP_NOP   = 3'd0;
  localparam logic [2:0] OP_ACT   = 3'd1;
  localparam logic [2:0] OP_READ  = 3'd2;
  localparam logic [2:0] OP_WRITE = 3'd3;
  localparam logic [2:0] OP_PRE   = 3'd4;
  localparam logic [2:0] OP_REF   = 3'd5;

  // strobes from control to datapath, one-hot per bank where applicable
  typedef struct packed {
    logic [NUM_BANKS-1:0] act;
    logic [NUM_BANKS-1:0] pre;
    logic [NUM_BANKS-1:0] col;
    logic                 autoPre;
    logic [AP_W-1:0]      apDelay;
    logic                 refresh;
  } strobe_t;

  // bank state seen by control
  typedef struct packed {
    logic [NUM_BANKS-1:0] open;
    logic [NUM_BANKS-1:0] rcdDone;
    logic [NUM_BANKS-1:0] rpDone;
    logic [NUM_BANKS-1:0] rcDone;
    logic [NUM_BANKS-1:0] apPend;
  } bank_status_t;

  function automatic int nsToCycles(longint ns, longint periodPs);
    return int'((ns * 64'd1000 + periodPs - 64'd1) / periodPs);
  endfunction

endpackage

// File: rtl/bank_timing_ctl.sv
module bank_timing_ctl
  import bank_timing_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [BANK_W-1:0] cmdBank,
  input  logic              cmdAutoPre,
  input  logic [2:0]        modeCl,
  input  logic [2:0]        modeAl,
  input  logic              modeBurst8,
  input  bank_status_t      status,
  output strobe_t           stb,
  output logic              cmdAccept,
  output logic              cmdViolation,
  output logic [3:0]        readLatency,
  output logic [3:0]        writeLatency
);

  logic [NUM_BANKS-1:0] bankSel;
  logic                 modeOk;
  logic                 isCmd;
  logic                 legal;
  logic                 fire;
  logic [AP_W-1:0]      burstHalf;

  always_comb begin
    readLatency  = {1'b0, modeAl} + {1'b0, modeCl};
    writeLatency = readLatency - 4'd1;
    modeOk       = ((modeCl == 3'd3) || (modeCl == 3'd4)) && (modeAl <= 3'd4);
    burstHalf    = modeBurst8 ? AP_W'(4) : AP_W'(2);
  end

  always_comb begin
    bankSel          = '0;
    bankSel[cmdBank] = 1'b1;
    legal            = 1'b0;
    case (cmdOp)
      OP_ACT:   legal = !status.open[cmdBank] && status.rpDone[cmdBank]
                        && status.rcDone[cmdBank];
      OP_READ,
      OP_WRITE: legal = status.open[cmdBank] && status.rcdDone[cmdBank]
                        && !status.apPend[cmdBank] && modeOk;
      OP_PRE:   legal = !status.apPend[cmdBank];
      OP_REF:   legal = (status.open == '0) && (&status.rpDone)
                        && (status.apPend == '0);
      default:  legal = 1'b0;
    endcase
    isCmd = cmdValid && (cmdOp != OP_NOP);
    fire  = isCmd && legal;
  end

  always_comb begin
    stb         = '0;
    stb.autoPre = cmdAutoPre;
    stb.apDelay = ((cmdOp == OP_WRITE) ? {1'b0, writeLatency} : {2'b00, modeAl})
                  + burstHalf;
    if (fire) begin
      if (cmdOp == OP_ACT) stb.act = bankSel;
      if (cmdOp == OP_PRE) stb.pre = bankSel;
      if (cmdOp == OP_READ || cmdOp == OP_WRITE) stb.col = bankSel;
      if (cmdOp == OP_REF) stb.refresh = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdAccept    <= 1'b0;
      cmdViolation <= 1'b0;
    end else begin
      cmdAccept    <= fire;
      cmdViolation <= isCmd && !legal;
    end
  end

  a_r9_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp != OP_NOP) |=> (cmdAccept != cmdViolation));

  a_r9_quiet_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdValid || cmdOp == OP_NOP) |=> (!cmdAccept && !cmdViolation));

endmodule

// File: rtl/bank_timing_dp.sv
module bank_timing_dp
  import bank_timing_pkg::*;
#(
  parameter int RCD_CYC  = 3,
  parameter int RP_CYC   = 3,
  parameter int RC_CYC   = 12,
  parameter int REFI_CYC = 1562
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [BANK_W-1:0] cmdBank,
  input  logic [ROW_W-1:0]  cmdRow,
  input  logic [COL_W-1:0]  cmdCol,
  output bank_status_t      status,
  output logic [NUM_BANKS-1:0] bankOpen,
  output logic [NUM_BANKS-1:0] autoPreFire,
  output logic [ROW_W-1:0]  colRow,
  output logic [COL_W-1:0]  colAddr,
  output logic              refreshDue,
  output logic [ROW_W-1:0]  refreshRow
);

  localparam int MAX_T = (RC_CYC > RP_CYC)
                         ? ((RC_CYC > RCD_CYC) ? RC_CYC : RCD_CYC)
                         : ((RP_CYC > RCD_CYC) ? RP_CYC : RCD_CYC);
  localparam int CNT_W = $clog2(MAX_T + 1);
  localparam int REF_W = $clog2(REFI_CYC);

  logic             openQ  [NUM_BANKS];
  logic [CNT_W-1:0] rcdCnt [NUM_BANKS];
  logic [CNT_W-1:0] rpCnt  [NUM_BANKS];
  logic [CNT_W-1:0] rcCnt  [NUM_BANKS];
  logic [AP_W-1:0]  apCnt  [NUM_BANKS];
  logic             apPend [NUM_BANKS];
  logic             apFire [NUM_BANKS];
  logic [ROW_W-1:0] rowQ   [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic closeNow;
    assign apFire[b] = apPend[b] && (apCnt[b] == '0);
    assign closeNow  = (stb.pre[b] && openQ[b]) || apFire[b];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        openQ[b]  <= 1'b0;
        rcdCnt[b] <= '0;
        rpCnt[b]  <= '0;
        rcCnt[b]  <= '0;
        apCnt[b]  <= '0;
        apPend[b] <= 1'b0;
        rowQ[b]   <= '0;
      end else begin
        if (stb.act[b]) begin
          openQ[b]  <= 1'b1;
          rowQ[b]   <= cmdRow;
          rcdCnt[b] <= CNT_W'(RCD_CYC - 1);
          rcCnt[b]  <= CNT_W'(RC_CYC - 1);
        end else begin
          if (closeNow) openQ[b] <= 1'b0;
          if (rcdCnt[b] != '0) rcdCnt[b] <= rcdCnt[b] - 1'b1;
          if (rcCnt[b] != '0)  rcCnt[b]  <= rcCnt[b] - 1'b1;
        end
        if (closeNow)             rpCnt[b] <= CNT_W'(RP_CYC - 1);
        else if (rpCnt[b] != '0)  rpCnt[b] <= rpCnt[b] - 1'b1;

        if (stb.col[b] && stb.autoPre) begin
          apPend[b] <= 1'b1;
          apCnt[b]  <= stb.apDelay - 1'b1;
        end else if (apFire[b]) begin
          apPend[b] <= 1'b0;
        end else if (apPend[b]) begin
          apCnt[b]  <= apCnt[b] - 1'b1;
        end
      end
    end

    a_r1_act_to_idle_bank: assert property (@(posedge clk) disable iff (!rstN)
      stb.act[b] |-> (!openQ[b] && rpCnt[b] == '0 && rcCnt[b] == '0));

    a_r2_col_after_rcd: assert property (@(posedge clk) disable iff (!rstN)
      stb.col[b] |-> (openQ[b] && rcdCnt[b] == '0 && !apPend[b]));

    a_r6_fire_closes_bank: assert property (@(posedge clk) disable iff (!rstN)
      apFire[b] |=> (!openQ[b] && rpCnt[b] != '0));
  end

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      status.open[b]    = openQ[b];
      status.rcdDone[b] = (rcdCnt[b] == '0);
      status.rpDone[b]  = (rpCnt[b] == '0);
      status.rcDone[b]  = (rcCnt[b] == '0);
      status.apPend[b]  = apPend[b];
      bankOpen[b]       = openQ[b];
      autoPreFire[b]    = apFire[b];
    end
  end

  // last accepted column access
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colRow  <= '0;
      colAddr <= '0;
    end else if (stb.col != '0) begin
      colRow  <= rowQ[cmdBank];
      colAddr <= cmdCol;
    end
  end

  // refresh interval and row pointer
  logic [REF_W-1:0] refCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refCnt     <= '0;
      refreshDue <= 1'b0;
      refreshRow <= '0;
    end else begin
      if (stb.refresh) begin
        refreshDue <= 1'b0;
        refreshRow <= refreshRow + 1'b1;
      end
      if (refCnt == REF_W'(REFI_CYC - 1)) begin
        refCnt     <= '0;
        refreshDue <= 1'b1;
      end else begin
        refCnt <= refCnt + 1'b1;
      end
    end
  end

  a_r7_refresh_all_idle: assert property (@(posedge clk) disable iff (!rstN)
    stb.refresh |-> (bankOpen == '0));

  a_r7_row_step: assert property (@(posedge clk) disable iff (!rstN)
    stb.refresh |=> (refreshRow == $past(refreshRow) + ROW_W'(1)));

endmodule

// File: rtl/bank_timing_ctrl.sv
module bank_timing_ctrl
  import bank_timing_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 5000,
  parameter int T_RCD_NS      = 15,
  parameter int T_RP_NS       = 15,
  parameter int T_RC_NS       = 60,
  parameter longint REF_WINDOW_NS = 64_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [1:0]        cmdBank,
  input  logic [12:0]       cmdRow,
  input  logic [9:0]        cmdCol,
  input  logic              cmdAutoPre,
  input  logic [2:0]        modeCl,
  input  logic [2:0]        modeAl,
  input  logic              modeBurst8,
  output logic              cmdAccept,
  output logic              cmdViolation,
  output logic [3:0]        readLatency,
  output logic [3:0]        writeLatency,
  output logic [3:0]        bankOpen,
  output logic [3:0]        autoPreFire,
  output logic [12:0]       colRow,
  output logic [9:0]        colAddr,
  output logic              refreshDue,
  output logic [12:0]       refreshRow
);

  localparam int RCD_CYC  = nsToCycles(T_RCD_NS, CLK_PERIOD_PS);
  localparam int RP_CYC   = nsToCycles(T_RP_NS, CLK_PERIOD_PS);
  localparam int RC_CYC   = nsToCycles(T_RC_NS, CLK_PERIOD_PS);
  localparam longint REF_ROWS = longint'(1) << ROW_W;
  localparam int REFI_CYC = int'((REF_WINDOW_NS * 64'd1000)
                                 / (REF_ROWS * longint'(CLK_PERIOD_PS)));

  strobe_t      stb;
  bank_status_t status;

  bank_timing_ctl u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .cmdValid     (cmdValid),
    .cmdOp        (cmdOp),
    .cmdBank      (cmdBank),
    .cmdAutoPre   (cmdAutoPre),
    .modeCl       (modeCl),
    .modeAl       (modeAl),
    .modeBurst8   (modeBurst8),
    .status       (status),
    .stb          (stb),
    .cmdAccept    (cmdAccept),
    .cmdViolation (cmdViolation),
    .readLatency  (readLatency),
    .writeLatency (writeLatency)
  );

  bank_timing_dp #(
    .RCD_CYC  (RCD_CYC),
    .RP_CYC   (RP_CYC),
    .RC_CYC   (RC_CYC),
    .REFI_CYC (REFI_CYC)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .cmdBank     (cmdBank),
    .cmdRow      (cmdRow),
    .cmdCol      (cmdCol),
    .status      (status),
    .bankOpen    (bankOpen),
    .autoPreFire (autoPreFire),
    .colRow      (colRow),
    .colAddr     (colAddr),
    .refreshDue  (refreshDue),
    .refreshRow  (refreshRow)
  );

endmodule

// File: tb/bank_timing_ctrl_tb.sv
`timescale 1ns/1ps
module bank_timing_ctrl_tb;

  localparam int REFI = 1562;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmdOp = 3'd0;
  logic [1:0]  cmdBank = 2'd0;
  logic [12:0] cmdRow = '0;
  logic [9:0]  cmdCol = '0;
  logic        cmdAutoPre = 1'b0;
  logic [2:0]  modeCl = 3'd3;
  logic [2:0]  modeAl = 3'd0;
  logic        modeBurst8 = 1'b0;
  logic        cmdAccept, cmdViolation, refreshDue;
  logic [3:0]  readLatency, writeLatency, bankOpen, autoPreFire;
  logic [12:0] colRow, refreshRow;
  logic [9:0]  colAddr;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  bank_timing_ctrl u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdBank(cmdBank), .cmdRow(cmdRow), .cmdCol(cmdCol),
    .cmdAutoPre(cmdAutoPre), .modeCl(modeCl), .modeAl(modeAl),
    .modeBurst8(modeBurst8), .cmdAccept(cmdAccept),
    .cmdViolation(cmdViolation), .readLatency(readLatency),
    .writeLatency(writeLatency), .bankOpen(bankOpen),
    .autoPreFire(autoPreFire), .colRow(colRow), .colAddr(colAddr),
    .refreshDue(refreshDue), .refreshRow(refreshRow)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  bank;
    logic [12:0] row;
    logic [9:0]  col;
    logic        ap;
    logic        expAcc;
    logic        expVio;
    logic        chkCol;
  } vec_t;

  // CL3 AL0 BL4, one command per cycle starting at edge 0
  localparam vec_t VECS [15] = '{
    '{3'd1, 2'd0, 13'h0155, 10'd0,   1'b0, 1'b1, 1'b0, 1'b0}, // k0 act b0
    '{3'd2, 2'd0, 13'h0000, 10'd1,   1'b0, 1'b0, 1'b1, 1'b0}, // k1 read too early
    '{3'd1, 2'd1, 13'h00AA, 10'd0,   1'b0, 1'b1, 1'b0, 1'b0}, // k2 act b1
    '{3'd2, 2'd0, 13'h0000, 10'd5,   1'b0, 1'b1, 1'b0, 1'b1}, // k3 read b0 at tRCD
    '{3'd1, 2'd0, 13'h0001, 10'd0,   1'b0, 1'b0, 1'b1, 1'b0}, // k4 act open bank
    '{3'd3, 2'd1, 13'h0000, 10'h3FF, 1'b0, 1'b1, 1'b0, 1'b1}, // k5 write b1
    '{3'd4, 2'd0, 13'h0000, 10'd0,   1'b0, 1'b1, 1'b0, 1'b0}, // k6 pre b0
    '{3'd1, 2'd0, 13'h0002, 10'd0,   1'b0, 1'b0, 1'b1, 1'b0}, // k7 inside tRP
    '{3'd0, 2'd0, 13'h0000, 10'd0,   1'b0, 1'b0, 1'b0, 1'b0}, // k8 nop
    '{3'd1, 2'd0, 13'h0003, 10'd0,   1'b0, 1'b0, 1'b1, 1'b0}, // k9 inside tRC
    '{3'd5, 2'd0, 13'h0000, 10'd0,   1'b0, 1'b0, 1'b1, 1'b0}, // k10 ref with b1 open
    '{3'd7, 2'd0, 13'h0000, 10'd0,   1'b0, 1'b0, 1'b1, 1'b0}, // k11 bad code
    '{3'd1, 2'd0, 13'h1FFF, 10'd0,   1'b0, 1'b1, 1'b0, 1'b0}, // k12 tRC met
    '{3'd4, 2'd2, 13'h0000, 10'd0,   1'b0, 1'b1, 1'b0, 1'b0}, // k13 pre idle b2
    '{3'd1, 2'd2, 13'h0042, 10'd0,   1'b0, 1'b1, 1'b0, 1'b0}  // k14 act b2 at once
  };
  localparam logic [12:0] VEC_ROWS [15] = '{
    13'h0, 13'h0, 13'h0, 13'h0155, 13'h0, 13'h00AA, 13'h0, 13'h0,
    13'h0, 13'h0, 13'h0, 13'h0, 13'h0, 13'h0, 13'h0};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    cmdValid = 1'b0;
    cmdOp = 3'd0;
    cmdAutoPre = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic issue(input logic [2:0] op, input logic [1:0] bank,
                       input logic [12:0] row, input logic [9:0] col, input logic ap);
    cmdValid = 1'b1; cmdOp = op; cmdBank = bank; cmdRow = row;
    cmdCol = col; cmdAutoPre = ap;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 3'd0; cmdAutoPre = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int rejects;
    @(negedge clk);
    doReset();
    // R9 reset state
    chk("R9 reset bankOpen", bankOpen, 0);
    chk("R9 reset flags", {cmdAccept, cmdViolation, refreshDue}, 0);
    chk("R9 reset fire", autoPreFire, 0);
    chk("R7 reset refreshRow", refreshRow, 0);

    // vector table: R1 R2 R3 R4 R7 R9
    for (int i = 0; i < 15; i++) begin
      issue(VECS[i].op, VECS[i].bank, VECS[i].row, VECS[i].col, VECS[i].ap);
      chk($sformatf("R1/R2/R3/R4/R9 vec%0d accept", i), cmdAccept, VECS[i].expAcc);
      chk($sformatf("R1/R2/R3/R4/R9 vec%0d violation", i), cmdViolation, VECS[i].expVio);
      if (VECS[i].chkCol) begin
        chk($sformatf("R2 vec%0d colRow", i), colRow, VEC_ROWS[i]);
        chk($sformatf("R2 vec%0d colAddr", i), colAddr, VECS[i].col);
      end
    end
    chk("R3 banks open after table", bankOpen, 4'b0111);

    // R5 latencies and mode legality
    doReset();
    modeCl = 3'd4; modeAl = 3'd3; #1;
    chk("R5 read latency 7", readLatency, 7);
    chk("R5 write latency 6", writeLatency, 6);
    modeCl = 3'd3; modeAl = 3'd0; #1;
    chk("R5 read latency 3", readLatency, 3);
    chk("R5 write latency 2", writeLatency, 2);
    @(negedge clk);
    issue(3'd1, 2'd3, 13'h0777, 10'd0, 1'b0);
    idle(2);
    modeCl = 3'd5;
    issue(3'd2, 2'd3, 13'h0, 10'd9, 1'b0);
    chk("R5 CL5 refused", cmdViolation, 1);
    modeCl = 3'd3; modeAl = 3'd5;
    issue(3'd2, 2'd3, 13'h0, 10'd9, 1'b0);
    chk("R5 AL5 refused", cmdViolation, 1);
    modeCl = 3'd4; modeAl = 3'd4;
    issue(3'd2, 2'd3, 13'h0, 10'd9, 1'b0);
    chk("R5 CL4 AL4 accepted", cmdAccept, 1);
    chk("R2 row kept for b3", colRow, 13'h0777);

    // R6 auto precharge after read: AL2 BL8 -> D=6
    doReset();
    modeCl = 3'd3; modeAl = 3'd2; modeBurst8 = 1'b1;
    issue(3'd1, 2'd1, 13'h0123, 10'd0, 1'b0);
    idle(2);
    issue(3'd2, 2'd1, 13'h0, 10'd4, 1'b1);
    chk("R6 read ap accepted", cmdAccept, 1);
    idle(4);
    chk("R6 no early fire", autoPreFire, 0);
    idle(1);
    chk("R6 fire read", autoPreFire, 4'b0010);
    chk("R6 still open during fire", bankOpen, 4'b0010);
    idle(1);
    chk("R6 closed after fire", bankOpen, 0);
    chk("R6 fire is a pulse", autoPreFire, 0);
    idle(1);
    issue(3'd1, 2'd1, 13'h0124, 10'd0, 1'b0);
    chk("R6 act inside tRP after ap", cmdViolation, 1);
    issue(3'd1, 2'd1, 13'h0124, 10'd0, 1'b0);
    chk("R6 act at tRP after ap", cmdAccept, 1);

    // R6 auto precharge after write: CL4 AL0 BL4 -> WL3, D=5
    doReset();
    modeCl = 3'd4; modeAl = 3'd0; modeBurst8 = 1'b0;
    issue(3'd1, 2'd2, 13'h0055, 10'd0, 1'b0);
    idle(2);
    issue(3'd3, 2'd2, 13'h0, 10'd2, 1'b1);
    chk("R6 write ap accepted", cmdAccept, 1);
    issue(3'd2, 2'd2, 13'h0, 10'd3, 1'b0);
    chk("R6 read while pending refused", cmdViolation, 1);
    issue(3'd4, 2'd2, 13'h0, 10'd0, 1'b0);
    chk("R4 pre while pending refused", cmdViolation, 1);
    idle(1);
    chk("R6 write no early fire", autoPreFire, 0);
    idle(1);
    chk("R6 fire write", autoPreFire, 4'b0100);
    idle(1);
    chk("R6 write bank closed", bankOpen, 0);

    // R8 refresh interval, R7 refresh rules
    doReset();
    modeCl = 3'd3;
    idle(REFI - 1);
    chk("R8 due low before interval", refreshDue, 0);
    idle(1);
    chk("R8 due high at interval", refreshDue, 1);
    issue(3'd1, 2'd0, 13'h0010, 10'd0, 1'b0);
    issue(3'd5, 2'd0, 13'h0, 10'd0, 1'b0);
    chk("R7 refresh with open bank refused", cmdViolation, 1);
    chk("R7 row unchanged on refusal", refreshRow, 0);
    idle(1);
    issue(3'd4, 2'd0, 13'h0, 10'd0, 1'b0);
    issue(3'd5, 2'd0, 13'h0, 10'd0, 1'b0);
    chk("R7 refresh inside tRP refused", cmdViolation, 1);
    idle(1);
    issue(3'd5, 2'd0, 13'h0, 10'd0, 1'b0);
    chk("R7 refresh accepted", cmdAccept, 1);
    chk("R7 row advanced", refreshRow, 1);
    chk("R8 due cleared", refreshDue, 0);

    // R7 wrap of the refresh row pointer
    doReset();
    rejects = 0;
    for (int i = 0; i < 8192; i++) begin
      issue(3'd5, 2'd0, 13'h0, 10'd0, 1'b0);
      if (!cmdAccept) rejects++;
    end
    chk("R7 back-to-back refreshes accepted", rejects, 0);
    chk("R7 row wraps to zero", refreshRow, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule